// File: doc/BRIEF.md
# Serial Bit Clock Generator

This block produces the bit clock that paces a buffered serial port. It divides one of two time bases. The first is the system clock divided by two. The second is an external reference clock, which is brought into the system clock domain through a synchronizer and then used only as an enable. An 8-bit divide value sets the bit clock period and sets how that period splits between high and low. A polarity bit can invert the output. Alongside the clock level, the block gives one-cycle pulses on each rising and each falling output edge, plus a strobe at the end of every full period.

Internally the divider counts half input periods. In system-clock mode every system clock cycle is one half period. In external mode every edge of the synchronized reference, rising or falling, is one half period. This lets a divide value of zero give a bit clock of one input period with equal halves. Configuration is captured at the start of each bit clock period, so a change never cuts a phase short. The pins carry no data, so none of them has a handshake. Every pin is a plain control or status level.

Top module: `bitclk_gen`

## Requirements
- R1: While `rst_n` or `en` is low, `bclk`, `rise_pls`, `fall_pls` and `period_done` are all 0. In the cycle after `en` is sampled low they are 0, with no falling pulse produced by the drop.
- R2: With `src_sel`=1 (system clock divided by two) and a divide value of 0, the bit clock is high for 1 system cycle and low for 1 system cycle. This is the shortest period, 2 system cycles.
- R3: For an even, nonzero divide value G, the high phase is G/2+1 input periods and the low phase is G/2 input periods. With `src_sel`=1 that is G+2 and G system cycles.
- R4: For an odd divide value G, both phases are (G+1)/2 input periods. With `src_sel`=1 that is G+1 system cycles each.
- R5: With `src_sel`=0, each edge of the synchronized `ext_ref`, rising or falling, counts as half an input period. If `ext_ref` toggles every K system cycles, a phase of N input periods lasts 2·N·K system cycles.
- R6: With `pol`=1 the output is inverted: high and low phase lengths swap. The period reference edge becomes the falling edge of `bclk`.
- R7: `rise_pls` is 1 exactly in the first cycle `bclk` is 1. `fall_pls` is 1 exactly in the first cycle `bclk` is 0 after being 1. The two are never 1 together.
- R8: `period_done` is 1 for one cycle at the end of each full period. It coincides with the reference edge pulse (`rise_pls` for `pol`=0, `fall_pls` for `pol`=1). It is not asserted at the first output edge after enabling.
- R9: `div_val`, `src_sel` and `pol` are sampled at enable start and at each period end. A change made in mid-period leaves the current period unchanged and applies from the next one.
- R10: With `src_sel`=1 and `pol`=0, `bclk` and `rise_pls` become 1 after the second rising clock edge at which `en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Generator enable; low holds the output idle |
| src_sel | input | 1 | 1: system clock divided by two; 0: external reference |
| ext_ref | input | 1 | External reference clock, asynchronous |
| div_val | input | 8 | Divide value G |
| pol | input | 1 | Output polarity; 1 inverts the bit clock |
| bclk | output | 1 | Bit clock level |
| rise_pls | output | 1 | One-cycle pulse on a rising output edge |
| fall_pls | output | 1 | One-cycle pulse on a falling output edge |
| period_done | output | 1 | One-cycle strobe at each period end |

## Verification
A corrupted phase counter shows at the pins within one bit clock phase: the spacing between `rise_pls` and `fall_pls` no longer matches the length that the captured divide value calls for. A wrong phase flag or a stale captured configuration shows by the next period boundary at the latest, as a misplaced `period_done` or as a new divide value applied in mid-period. Lost enable gating appears one cycle after `en` falls, as a nonzero `bclk` or a stray pulse.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_SYS = 1'b1
  } src_e;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } phase_e;
endpackage

// File: rtl/bclk_ref_sync.sv
// Synchronizes the external reference and flags each of its edges.
module bclk_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic edge_pls
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar i;
  generate
    for (i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= ref_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  // any change of the synchronized level marks half an input period
  assign edge_pls = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/bclk_tick_sel.sv
// Chooses which half-period enable drives the divider.
module bclk_tick_sel
  import bclk_pkg::*;
(
  input  src_e src,
  input  logic ext_edge,
  output logic tick
);
  always_comb begin
    unique case (src)
      SRC_SYS: tick = 1'b1;
      SRC_EXT: tick = ext_edge;
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/bclk_phase_ctr.sv
// Counts half input periods and alternates the raw phase.
module bclk_phase_ctr
  import bclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_val,
  input  logic             src_sel,
  input  logic             pol,
  output logic             running,
  output phase_e           phase,
  output logic             pol_q,
  output src_e             src_eff,
  output logic             period_end
);
  localparam int LEN_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  src_e             src_q;
  logic [LEN_W-1:0] rem_q;

  function automatic logic [LEN_W-1:0] hi_len(input logic [DIV_W-1:0] g);
    if (g == '0)   return LEN_W'(1);
    else if (g[0]) return {1'b0, g} + LEN_W'(1);
    else           return {1'b0, g} + LEN_W'(2);
  endfunction

  function automatic logic [LEN_W-1:0] lo_len(input logic [DIV_W-1:0] g);
    if (g == '0)   return LEN_W'(1);
    else if (g[0]) return {1'b0, g} + LEN_W'(1);
    else           return {1'b0, g};
  endfunction

  // before start the requested source decides which ticks count
  assign src_eff = running ? src_q : src_e'(src_sel);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      running    <= 1'b0;
      phase      <= PH_LO;
      rem_q      <= '0;
      period_end <= 1'b0;
      div_q      <= '0;
      src_q      <= SRC_EXT;
      pol_q      <= 1'b0;
    end else begin
      period_end <= 1'b0;
      if (tick) begin
        if (!running) begin
          running <= 1'b1;
          phase   <= PH_HI;
          div_q   <= div_val;
          src_q   <= src_e'(src_sel);
          pol_q   <= pol;
          rem_q   <= hi_len(div_val) - LEN_W'(1);
        end else if (rem_q != '0) begin
          rem_q <= rem_q - LEN_W'(1);
        end else if (phase == PH_HI) begin
          phase <= PH_LO;
          rem_q <= lo_len(div_q) - LEN_W'(1);
        end else begin
          phase      <= PH_HI;
          period_end <= 1'b1;
          div_q      <= div_val;
          src_q      <= src_e'(src_sel);
          pol_q      <= pol;
          rem_q      <= hi_len(div_val) - LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bclk_out_stage.sv
// Applies polarity and registers the level, edge pulses and period strobe.
module bclk_out_stage
  import bclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   running,
  input  phase_e phase,
  input  logic   pol_q,
  input  logic   period_end,
  output logic   bclk,
  output logic   rise_pls,
  output logic   fall_pls,
  output logic   period_done
);
  logic active;
  logic lvl_n;

  assign active = en & running;
  assign lvl_n  = active & ((phase == PH_HI) ^ pol_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk        <= 1'b0;
      rise_pls    <= 1'b0;
      fall_pls    <= 1'b0;
      period_done <= 1'b0;
    end else begin
      bclk        <= lvl_n;
      rise_pls    <= lvl_n & ~bclk;
      fall_pls    <= active & ~lvl_n & bclk;
      period_done <= en & period_end;
    end
  end
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             src_sel,
  input  logic             ext_ref,
  input  logic [DIV_W-1:0] div_val,
  input  logic             pol,
  output logic             bclk,
  output logic             rise_pls,
  output logic             fall_pls,
  output logic             period_done
);
  logic   ext_edge;
  logic   tick;
  logic   running;
  phase_e phase;
  logic   pol_q;
  src_e   src_eff;
  logic   period_end;

  bclk_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ext_ref),
    .edge_pls (ext_edge)
  );

  bclk_tick_sel u_tsel (
    .src      (src_eff),
    .ext_edge (ext_edge),
    .tick     (tick)
  );

  bclk_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (tick),
    .div_val    (div_val),
    .src_sel    (src_sel),
    .pol        (pol),
    .running    (running),
    .phase      (phase),
    .pol_q      (pol_q),
    .src_eff    (src_eff),
    .period_end (period_end)
  );

  bclk_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .running     (running),
    .phase       (phase),
    .pol_q       (pol_q),
    .period_end  (period_end),
    .bclk        (bclk),
    .rise_pls    (rise_pls),
    .fall_pls    (fall_pls),
    .period_done (period_done)
  );
endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic bclk,
  input logic rise_pls,
  input logic fall_pls,
  input logic period_done
);
  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pls && fall_pls));

  // R7
  rise_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pls |-> (bclk && !$past(bclk)));

  // R7
  fall_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pls |-> (!bclk && $past(bclk)));

  // R7
  edge_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> rise_pls);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && !rise_pls && !fall_pls && !period_done));

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (rise_pls || fall_pls));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done);

  // R2
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pls |=> !rise_pls);
endmodule

bind bitclk_gen bitclk_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .bclk        (bclk),
  .rise_pls    (rise_pls),
  .fall_pls    (fall_pls),
  .period_done (period_done)
);

// File: tb/sim_bitclk_gen.sv
module sim_bitclk_gen;
  localparam int CLK_P   = 10;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       src_sel = 1'b1;
  logic       ext_ref = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic       pol = 1'b0;
  logic       bclk, rise_pls, fall_pls, period_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int ext_half = 0;

  bitclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .ext_ref(ext_ref),
    .div_val(div_val), .pol(pol), .bclk(bclk), .rise_pls(rise_pls),
    .fall_pls(fall_pls), .period_done(period_done)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // external reference: toggles every ext_half cycles when nonzero
  always begin
    @(negedge clk);
    if (ext_half > 0) begin
      for (int k = 1; k < ext_half; k++) @(negedge clk);
      ext_ref = ~ext_ref;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic restart(input bit s, input int g, input bit p);
    @(negedge clk);
    en = 1'b0; src_sel = s; div_val = 8'(g); pol = p;
    @(negedge clk);
    en = 1'b1;
  endtask

  // measures output high/low lengths from the first rise pulse after start
  task automatic measure(output int hi, output int lo, output bit d_r0,
                         output bit d_f, output bit d_r1);
    int tr, tf;
    do @(negedge clk); while (!rise_pls);
    tr = cyc; d_r0 = period_done;
    do @(negedge clk); while (!fall_pls);
    tf = cyc; d_f = period_done;
    do @(negedge clk); while (!rise_pls);
    d_r1 = period_done;
    hi = tf - tr; lo = cyc - tf;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!bclk && !rise_pls && !fall_pls && !period_done, "R1 reset idle",
        {bclk, rise_pls, fall_pls, period_done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bclk && !rise_pls, "R1 disabled idle", {bclk, rise_pls}, 0);
  endtask

  task automatic t_sys(input int g, input int ehi, input int elo, input string req);
    int hi, lo; bit d0, df, d1;
    restart(1'b1, g, 1'b0);
    measure(hi, lo, d0, df, d1);
    chk(hi == ehi, req, hi, ehi);
    chk(lo == elo, req, lo, elo);
    chk(!d0 && !df && d1, "R8 period_done at rise only", {d0, df, d1}, 1);
  endtask

  task automatic t_start;
    @(negedge clk); en = 1'b0; src_sel = 1'b1; div_val = 8'd2; pol = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    chk(!bclk, "R10 low after first edge", bclk, 0);
    @(negedge clk);
    chk(bclk && rise_pls && !period_done, "R10 rise after second edge",
        {bclk, rise_pls, period_done}, 6);
  endtask

  task automatic t_ext(input int k, input int g, input int ehi, input int elo);
    int hi, lo; bit d0, df, d1;
    ext_half = k;
    restart(1'b0, g, 1'b0);
    measure(hi, lo, d0, df, d1);
    chk(hi == ehi, "R5 ext high length", hi, ehi);
    chk(lo == elo, "R5 ext low length", lo, elo);
    ext_half = 0;
  endtask

  task automatic t_pol;
    int hi, lo; bit d0, df, d1;
    restart(1'b1, 2, 1'b1);
    measure(hi, lo, d0, df, d1);
    chk(hi == 2, "R6 inverted high length", hi, 2);
    chk(lo == 4, "R6 inverted low length", lo, 4);
    chk(df && !d1, "R6 period_done on fall", {df, d1}, 2);
  endtask

  task automatic t_change;
    int t0, t;
    restart(1'b1, 3, 1'b0);
    do @(negedge clk); while (!rise_pls);
    t0 = cyc;
    div_val = 8'd1;
    do @(negedge clk); while (!fall_pls);
    t = cyc - t0; chk(t == 4, "R9 current high kept", t, 4);
    do @(negedge clk); while (!rise_pls);
    t = cyc - t0; chk(t == 8, "R9 current period kept", t, 8);
    do @(negedge clk); while (!fall_pls);
    t = cyc - t0; chk(t == 10, "R9 new value applied", t, 10);
  endtask

  task automatic t_drop;
    bit bad = 1'b0;
    restart(1'b1, 5, 1'b0);
    do @(negedge clk); while (!rise_pls);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!bclk && !fall_pls && !rise_pls && !period_done, "R1 drop to idle",
        {bclk, rise_pls, fall_pls, period_done}, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bclk || rise_pls || fall_pls || period_done) bad = 1'b1;
    end
    chk(!bad, "R1 stays idle", bad, 0);
  endtask

  task automatic t_excl;
    bit bad = 1'b0;
    restart(1'b1, 0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rise_pls && fall_pls) bad = 1'b1;
      if (rise_pls && !bclk) bad = 1'b1;
      if (fall_pls && bclk) bad = 1'b1;
    end
    chk(!bad, "R7 pulse and level agree", bad, 0);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYC, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_start();
    t_sys(0, 1, 1, "R2 divide zero");
    t_sys(4, 6, 4, "R3 even divide");
    t_sys(2, 4, 2, "R3 even divide small");
    t_sys(7, 8, 8, "R4 odd divide");
    t_sys(255, 256, 256, "R4 odd divide max");
    t_ext(3, 1, 6, 6);
    t_ext(3, 2, 12, 6);
    t_pol();
    t_change();
    t_drop();
    t_excl();
    finish_run();
  end
endmodule